// File: doc/BRIEF.md
# Multi-Cycle Integer Multiply/Divide Unit

This unit gives a small processor core the eight integer multiply and divide operations of the standard RISC-V multiply extension on 32-bit operands. It covers the low product word, three high product words (signed by signed, unsigned by unsigned, and signed by unsigned), signed and unsigned quotient, and signed and unsigned remainder. The core issues a request with a one-cycle `start` pulse together with an operation code and two operands. The unit latches all three and raises `busy` while it works. It then drives `done` high for exactly one cycle, and `result` holds the answer from that cycle until the next operation completes.

Multiplication forms one 64-bit product from sign- or zero-extended operands and finishes after a short fixed delay. Division runs a restoring shift-subtract loop on operand magnitudes and settles one quotient bit per clock. A fix-up step then applies signs and the instruction-set results for a zero divisor. Requests are accepted whenever `busy` is low, including the cycle in which `done` is high, so the core can issue operations back to back.

Top module: `mdu32`

## Requirements
- R1: `start` is accepted on a clock edge where `busy` is low. `busy` is high from the next cycle until the result is ready. `done` is then high for exactly one cycle with `busy` low.
- R2: Operation code 3'b000 returns bits 31:0 of the product of `a` and `b`.
- R3: Operation codes 3'b001 (both signed), 3'b011 (both unsigned) and 3'b010 (`a` signed, `b` unsigned) return bits 63:32 of the 64-bit product.
- R4: Operation codes 3'b100 (signed) and 3'b101 (unsigned) return the quotient `a / b`. Signed division rounds toward zero.
- R5: Operation codes 3'b110 (signed) and 3'b111 (unsigned) return the remainder, which takes the sign of the dividend for the signed form.
- R6: When `b` is zero, a quotient operation returns 32'hFFFFFFFF and a remainder operation returns `a`, for both signed and unsigned forms.
- R7: Signed division of 32'h80000000 by 32'hFFFFFFFF returns quotient 32'h80000000 and remainder 0.
- R8: `done` rises 2 clock cycles after the accepting edge for multiply codes and 34 cycles after it for divide codes.
- R9: After acceptance, changes on `a`, `b` and `op` do not affect the result of the operation in flight.
- R10: A `start` seen while `busy` is high is ignored. The running operation completes with its own result and latency, and no extra `done` follows.
- R11: A `start` in the cycle where `done` is high is accepted as a new operation.
- R12: While `rst_n` is low, `busy` and `done` are low and `result` is 0.
- R13: `result` changes only in a cycle in which `done` is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R2 to R5) |
| a | input | 32 | First operand (multiplicand / dividend) |
| b | input | 32 | Second operand (multiplier / divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid strobe |
| result | output | 32 | Result, held until the next completion |

## Verification
On every cycle the assertions check the shape of the handshake. `busy` and `done` are never high together, `done` lasts one cycle, an accepted request raises `busy`, and a multiply completes after exactly two cycles. They also check that `result` moves only when `done` is high. Only the bench scenarios can show the arithmetic itself: the signed, unsigned and mixed-sign high products, rounding toward zero, the zero-divisor and overflow values, and the 34-cycle divide latency. The bench scenarios also cover operand scrambling after acceptance, a start ignored mid-division, and a request issued in the `done` cycle.

// File: rtl/mdu32.sv
module mdu32 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W);

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_DIV, S_FIX, S_DONE} state_t;

  state_t        state;
  logic [2:0]    op_q;
  logic [W-1:0]  a_q, b_q, quo, rem, dvsr, res_q;
  logic [CW-1:0] cnt;
  logic          neg_q, neg_r;

  wire accept = start & ~busy;
  wire sdiv   = ~op[0];

  wire a_sx = (op_q == 3'b001) | (op_q == 3'b010);
  wire b_sx = (op_q == 3'b001);
  wire [2*W-1:0] ma   = {{W{a_sx & a_q[W-1]}}, a_q};
  wire [2*W-1:0] mb   = {{W{b_sx & b_q[W-1]}}, b_q};
  wire [2*W-1:0] prod = ma * mb;

  wire [W:0] shf  = {rem, quo[W-1]};
  wire [W:0] diff = shf - {1'b0, dvsr};

  wire [W-1:0] q_fix = neg_q ? (~quo + 1'b1) : quo;
  wire [W-1:0] r_fix = neg_r ? (~rem + 1'b1) : rem;

  assign busy   = (state == S_MUL) | (state == S_DIV) | (state == S_FIX);
  assign done   = (state == S_DONE);
  assign result = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      quo   <= '0;
      rem   <= '0;
      dvsr  <= '0;
      cnt   <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
      res_q <= '0;
    end else if (accept) begin
      op_q  <= op;
      a_q   <= a;
      b_q   <= b;
      quo   <= (sdiv & a[W-1]) ? (~a + 1'b1) : a;
      dvsr  <= (sdiv & b[W-1]) ? (~b + 1'b1) : b;
      rem   <= '0;
      cnt   <= '0;
      neg_q <= sdiv & (a[W-1] ^ b[W-1]);
      neg_r <= sdiv & a[W-1];
      state <= op[2] ? S_DIV : S_MUL;
    end else begin
      case (state)
        S_MUL: begin
          res_q <= (op_q == 3'b000) ? prod[W-1:0] : prod[2*W-1:W];
          state <= S_DONE;
        end
        S_DIV: begin
          if (!diff[W]) begin
            rem <= diff[W-1:0];
            quo <= {quo[W-2:0], 1'b1};
          end else begin
            rem <= shf[W-1:0];
            quo <= {quo[W-2:0], 1'b0};
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= S_FIX;
        end
        S_FIX: begin
          if (b_q == '0) res_q <= op_q[1] ? a_q : '1;
          else           res_q <= op_q[1] ? r_fix : q_fix;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdu32_chk.sv
module mdu32_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [2:0]   op,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_mul_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[2]) |=> ##1 done);

  assert_result_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

bind mdu32 mdu32_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op),
  .busy(busy), .done(done), .result(result)
);

// File: tb/mdu32_tb.sv
module mdu32_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  mdu32 u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .done(done), .result(result)
  );

  // {tag, op, a, b, expected}
  localparam int NV = 22;
  localparam logic [102:0] VEC [NV] = '{
    {4'd2, 3'b000, 32'h00000007, 32'h00000006, 32'h0000002A},
    {4'd2, 3'b000, 32'hFFFFFFFF, 32'h00000005, 32'hFFFFFFFB},
    {4'd3, 3'b001, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
    {4'd3, 3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE},
    {4'd3, 3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {4'd3, 3'b001, 32'h80000000, 32'h80000000, 32'h40000000},
    {4'd3, 3'b011, 32'h80000000, 32'h00000002, 32'h00000001},
    {4'd3, 3'b010, 32'h00000002, 32'h80000000, 32'h00000001},
    {4'd4, 3'b100, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFD},
    {4'd4, 3'b101, 32'hFFFFFFF9, 32'h00000002, 32'h7FFFFFFC},
    {4'd4, 3'b100, 32'h00000064, 32'hFFFFFFF9, 32'hFFFFFFF2},
    {4'd4, 3'b101, 32'h80000000, 32'hFFFFFFFF, 32'h00000000},
    {4'd4, 3'b101, 32'h000003E8, 32'h00000007, 32'h0000008E},
    {4'd5, 3'b110, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF},
    {4'd5, 3'b110, 32'h00000007, 32'hFFFFFFFE, 32'h00000001},
    {4'd5, 3'b111, 32'hFFFFFFF9, 32'h00000002, 32'h00000001},
    {4'd6, 3'b100, 32'h00000005, 32'h00000000, 32'hFFFFFFFF},
    {4'd6, 3'b101, 32'h00000005, 32'h00000000, 32'hFFFFFFFF},
    {4'd6, 3'b110, 32'hFFFFFFF9, 32'h00000000, 32'hFFFFFFF9},
    {4'd6, 3'b111, 32'h12345678, 32'h00000000, 32'h12345678},
    {4'd7, 3'b100, 32'h80000000, 32'hFFFFFFFF, 32'h80000000},
    {4'd7, 3'b110, 32'h80000000, 32'hFFFFFFFF, 32'h00000000}
  };

  function automatic string tname(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  // Issue a request, scramble the inputs after acceptance (R9), wait for done.
  task automatic run_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                        output logic [31:0] res, output int lat, output logic busy1);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0; op = ~o; a = ~x ^ 32'h5A5A5A5A; b = y + 32'd3;
    lat = 1;
    busy1 = busy;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin
    logic [31:0] r;
    logic        b1;
    int          lat;
    int          pulses;

    // R12: reset state
    @(negedge clk);
    @(negedge clk);
    chk("R12 busy", {31'd0, busy}, 32'd0);
    chk("R12 done", {31'd0, done}, 32'd0);
    chk("R12 result", result, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], r, lat, b1);
      chk(tname(VEC[i][102:99]), r, VEC[i][31:0]);
      chk("R8 latency", 32'(lat), VEC[i][98] ? 32'd34 : 32'd2);
      if (i == 0 || i == 8) chk("R1 busy after accept", {31'd0, b1}, 32'd1);
      if (i == 0) chk("R1 busy low at done", {31'd0, busy}, 32'd0);
    end

    // R10: start while busy is ignored
    @(negedge clk);
    start = 1'b1; op = 3'b100; a = 32'd100; b = 32'd7;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (lat >= 5 && lat < 8) begin
        start = 1'b1; op = 3'b000; a = 32'd3; b = 32'd3;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk("R10 result of running op", result, 32'd14);
    chk("R10 latency undisturbed", 32'(lat), 32'd34);
    pulses = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk("R10 no extra done", 32'(pulses), 32'd0);
    chk("R10 idle after", {31'd0, busy}, 32'd0);

    // R13: result holds while idle
    chk("R13 result held", result, 32'd14);

    // R11: back-to-back request in the done cycle
    run_op(3'b101, 32'd1000, 32'd7, r, lat, b1);
    chk("R11 first result", r, 32'd142);
    start = 1'b1; op = 3'b000; a = 32'd12; b = 32'd11;
    @(negedge clk);
    start = 1'b0;
    chk("R11 accepted in done cycle", {30'd0, busy, done}, 32'd2);
    chk("R13 result held before second done", result, 32'd142);
    @(negedge clk);
    chk("R11 second done", {31'd0, done}, 32'd1);
    chk("R11 second result", result, 32'd132);

    summary();
    $finish;
  end
endmodule